// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Register Interface

This block presents a byte-wide, 15-bit-addressed memory space to a host. The top eight addresses of that space are timekeeping registers; every other address reaches a plain byte store. The host sees a holding copy of the time registers. That copy is separate from the live BCD counters that a once-per-second tick advances. Two control bits let the host freeze the holding copy so that it can read a consistent time. They also let the host load a new time into the holding copy and then hand that time to the live counters in one step.

The interface is synchronous to a single clock. A request lasts one cycle, with chip enable `ce`, write enable `we` and output enable `oe` all active high. There is no back-pressure: every request is accepted in the cycle it is presented. Read data comes back exactly one cycle later, qualified by `rdata_drv`. When the power-good input is low, chip enable is forced inactive inside the block and the power-fail output goes low. The seconds register carries an oscillator-stop bit. The day register carries a frequency-test bit, which replaces the low bit of the seconds register, as read, with a toggle that flips on each fast tick. The byte store is a simple array of 2^RAM_AW bytes. Addresses outside the clock window alias modulo that depth.

Top module: `rtc_nvram_core`

## Requirements
- R1: Address 0x7FF8 is control, 0x7FF9 seconds, 0x7FFA minutes, 0x7FFB hours, 0x7FFC day of week, 0x7FFD date, 0x7FFE month and 0x7FFF year. Every other address is byte storage indexed by its low RAM_AW bits (default 10, so 0x0523 aliases 0x0123).
- R2: A cycle with `ce`=1 and `we`=1 is a write. A cycle with `ce`=1 and `we`=0 is a read. `rdata_drv` is 1 in the cycle after a read that had `oe`=1, and `rdata` then holds the addressed byte. Otherwise `rdata_drv` is 0 and `rdata` is 0x00.
- R3: Each `tick_1hz` pulse advances the live counters by one second in BCD, with carries from seconds (59 to 00) to minutes (59 to 00) to hours (23 to 00). When control bits 7 and 6 are both 0, the holding copy takes the new count at the same edge.
- R4: At the end of the last date of a month, the date goes to 01 and the month advances. The last date is 28 for February, 29 for February in a year divisible by 4, 30 for April, June, September and November, and 31 for the other months. Month 12 goes to 01 and the year advances; year 99 goes to 00. The day of week counts 1 to 7 and wraps to 1.
- R5: While control bit 6 (read hold) is 1, the holding time fields do not change, but the live counters keep counting. A write that clears bit 6 while leaving bit 7 at 0 reloads every holding field from the live counters at once, and the new values are readable in the next cycle.
- R6: While control bit 7 (write hold) is 1, the holding fields do not follow ticks and can be loaded by the host. A write that takes bit 7 from 1 to 0 copies the holding fields into the live counters. This copy happens even when the same write sets bit 6, and in that case the holding copy then stays frozen.
- R7: Seconds bit 7 set to 1 stops the live counters: ticks have no effect on the time until it is cleared.
- R8: When day bit 6 is 1 and seconds bit 7 is 0, bit 0 of the seconds register as read is an internal toggle. The toggle starts at 0 from reset and flips on each `tick_fast` pulse while the oscillator runs. Otherwise bit 0 reads the stored seconds bit.
- R9: Clock register bits that hold no time field are plain storage and keep their value across ticks. These are control bits 5:0, minutes bit 7, hours bits 7:6, day bits 7 and 5:3, date bits 7:6 and month bits 7:5.
- R10: While `pwr_ok` is 0, no read or write takes effect (no drive, no change to storage or registers) and `pfail_n` is 0.
- R11: After reset, control reads 0x00, seconds 0x80 (oscillator stopped), day, date and month 0x01, and year, hours and minutes 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good; low blocks every access |
| ce | input | 1 | Chip enable for this cycle's request |
| we | input | 1 | Write enable (1 write, 0 read) |
| oe | input | 1 | Output enable for a read request |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tick_fast | input | 1 | One-cycle pulse at the test rate |
| rdata | output | 8 | Read data, valid when rdata_drv is 1 |
| rdata_drv | output | 1 | Read data is being driven |
| pfail_n | output | 1 | Low while power is not good |

## Verification
A wrong holding copy surfaces on the very next register read. A wrong live counter stays hidden until the holding copy is refreshed, either by the next tick or by clearing the read-hold bit, so the bench reads after both kinds of refresh. Calendar errors show only at month and year boundaries. A transfer that is lost or ordered wrongly shows up one tick later as a seconds value off by one. The bench therefore sets times just before each boundary and reads the fields one tick after it.

// File: rtl/rtc_nv_pkg.sv
`timescale 1ns/1ps
package rtc_nv_pkg;

  localparam int NUM_REGS    = 8;
  localparam int CTRL_W_BIT  = 7;
  localparam int CTRL_R_BIT  = 6;
  localparam int OSC_BIT     = 7;
  localparam int FTEST_BIT   = 6;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mins;
    logic [7:0] secs;
  } tod_t;

  localparam tod_t TOD_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                 hr: 8'h00, mins: 8'h00, secs: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [3:0] o;
    o = y[3:0];
    if (!y[4]) return (o == 4'd0) || (o == 4'd4) || (o == 4'd8);
    else       return (o == 4'd2) || (o == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // bits of each clock register that carry a time field
  function automatic logic [7:0] field_mask(input logic [2:0] i);
    case (i)
      3'd1:    return 8'h7F;
      3'd2:    return 8'h7F;
      3'd3:    return 8'h3F;
      3'd4:    return 8'h07;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h1F;
      3'd7:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reset_byte(input logic [2:0] i);
    case (i)
      3'd1:             return 8'h80;
      3'd4, 3'd5, 3'd6: return 8'h01;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] tod_byte(input tod_t t, input logic [2:0] i);
    case (i)
      3'd1:    return t.secs;
      3'd2:    return t.mins;
      3'd3:    return t.hr;
      3'd4:    return t.dow;
      3'd5:    return t.date;
      3'd6:    return t.mon;
      3'd7:    return t.yr;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_byte_store.sv
`timescale 1ns/1ps
module rtc_byte_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [7:0]    d,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= d;
    q <= mem[a];
  end
endmodule

// File: rtl/rtc_live_count.sv
`timescale 1ns/1ps
module rtc_live_count
  import rtc_nv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic load,
  input  tod_t load_val,
  output tod_t cur,
  output tod_t nxt
);
  logic c_min, c_hr, c_day, c_mon;

  always_comb begin
    nxt   = cur;
    c_min = (cur.secs == 8'h59);
    c_hr  = c_min && (cur.mins == 8'h59);
    c_day = c_hr && (cur.hr == 8'h23);
    c_mon = c_day && (cur.date == month_last(cur.mon, cur.yr));
    nxt.secs = c_min ? 8'h00 : bcd_inc(cur.secs);
    if (c_min) nxt.mins = (cur.mins == 8'h59) ? 8'h00 : bcd_inc(cur.mins);
    if (c_hr)  nxt.hr   = (cur.hr == 8'h23) ? 8'h00 : bcd_inc(cur.hr);
    if (c_day) begin
      nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
      nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
    end
    if (c_mon) begin
      nxt.mon = (cur.mon == 8'h12) ? 8'h01 : bcd_inc(cur.mon);
      if (cur.mon == 8'h12) nxt.yr = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= TOD_RESET;
    else if (load) cur <= load_val;
    else if (adv)  cur <= nxt;
  end

  // R7: with no tick accepted and no transfer, the count holds
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> (cur == $past(cur)));

  // R3: seconds wrap from 59 to 00
  a_r3_sec_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur.secs == 8'h59) |=> (cur.secs == 8'h00));

  // R4: the last second of a month's last date starts a new month on date 01
  a_r4_month_start: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur.secs == 8'h59 && cur.mins == 8'h59 && cur.hr == 8'h23 &&
     cur.date == month_last(cur.mon, cur.yr)) |=> (cur.date == 8'h01));

  // R6: a transfer lands exactly the transferred values
  a_r6_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val)));
endmodule

// File: rtl/rtc_shadow_regs.sv
`timescale 1ns/1ps
module rtc_shadow_regs
  import rtc_nv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      widx,
  input  logic [7:0]      wdata,
  input  logic            adv,
  input  tod_t            live_cur,
  input  tod_t            live_nxt,
  output logic [7:0][7:0] regs,
  output logic            xfer,
  output tod_t            xfer_val
);
  logic [7:0] ctrl;
  logic       freeze, ctrl_wr, r_fall, refresh;
  tod_t       src;

  assign ctrl    = regs[0];
  assign freeze  = ctrl[CTRL_R_BIT] | ctrl[CTRL_W_BIT];
  assign ctrl_wr = wr_en && (widx == 3'd0);
  // write-hold release: transfer into the live counters (takes priority)
  assign xfer    = ctrl_wr && ctrl[CTRL_W_BIT] && !wdata[CTRL_W_BIT];
  // read-hold release with write hold already clear: refresh from the counters
  assign r_fall  = ctrl_wr && ctrl[CTRL_R_BIT] && !ctrl[CTRL_W_BIT] &&
                   !wdata[CTRL_R_BIT] && !wdata[CTRL_W_BIT];
  assign refresh = r_fall || (!freeze && adv);
  assign src     = adv ? live_nxt : live_cur;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam logic [2:0] IDX  = 3'(g);
    localparam logic [7:0] MASK = field_mask(IDX);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= reset_byte(IDX);
      else if (wr_en && widx == IDX)   q <= wdata;
      else if (refresh)                q <= (q & ~MASK) | (tod_byte(src, IDX) & MASK);
    end
    assign regs[g] = q;
  end

  always_comb begin
    xfer_val.secs = regs[1] & field_mask(3'd1);
    xfer_val.mins = regs[2] & field_mask(3'd2);
    xfer_val.hr   = regs[3] & field_mask(3'd3);
    xfer_val.dow  = regs[4] & field_mask(3'd4);
    xfer_val.date = regs[5] & field_mask(3'd5);
    xfer_val.mon  = regs[6] & field_mask(3'd6);
    xfer_val.yr   = regs[7] & field_mask(3'd7);
  end

  // R5/R6: with a hold bit set and no host write, the holding bytes stay put
  a_r5_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> (regs[7:1] == $past(regs[7:1])));

  // R9: spare bits of the minutes byte only change by a host write to it
  a_r9_spare_min_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && widx == 3'd2) |=> (regs[2][7] == $past(regs[2][7])));
endmodule

// File: rtl/rtc_nvram_core.sv
`timescale 1ns/1ps
module rtc_nvram_core
  import rtc_nv_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_ok,
  input  logic        ce,
  input  logic        we,
  input  logic        oe,
  input  logic [14:0] addr,
  input  logic [7:0]  wdata,
  input  logic        tick_1hz,
  input  logic        tick_fast,
  output logic [7:0]  rdata,
  output logic        rdata_drv,
  output logic        pfail_n
);
  localparam int AW = 15;
  localparam int IW = $clog2(NUM_REGS);

  logic            ce_eff, wr_req, rd_req, in_clk;
  logic [IW-1:0]   idx;
  logic [7:0][7:0] regs;
  logic            xfer, adv, osc_stop, ft_on;
  tod_t            xfer_val, live_cur, live_nxt;
  logic [7:0]      ram_q, rd_byte, clk_byte_q;
  logic            drv_q, in_clk_q, tog;

  assign ce_eff   = ce & pwr_ok;
  assign wr_req   = ce_eff & we;
  assign rd_req   = ce_eff & ~we;
  assign in_clk   = &addr[AW-1:IW];
  assign idx      = addr[IW-1:0];
  assign osc_stop = regs[1][OSC_BIT];
  assign ft_on    = regs[4][FTEST_BIT];
  assign adv      = tick_1hz & ~osc_stop;
  assign pfail_n  = pwr_ok;

  rtc_byte_store #(.AW(RAM_AW)) u_store (
    .clk (clk),
    .we  (wr_req & ~in_clk),
    .a   (addr[RAM_AW-1:0]),
    .d   (wdata),
    .q   (ram_q)
  );

  rtc_shadow_regs u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_req & in_clk),
    .widx     (idx),
    .wdata    (wdata),
    .adv      (adv),
    .live_cur (live_cur),
    .live_nxt (live_nxt),
    .regs     (regs),
    .xfer     (xfer),
    .xfer_val (xfer_val)
  );

  rtc_live_count u_live (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (xfer),
    .load_val (xfer_val),
    .cur      (live_cur),
    .nxt      (live_nxt)
  );

  always_comb begin
    rd_byte = regs[idx];
    if (idx == 3'd1 && ft_on && !osc_stop) rd_byte[0] = tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q      <= 1'b0;
      in_clk_q   <= 1'b0;
      clk_byte_q <= 8'h00;
      tog        <= 1'b0;
    end else begin
      drv_q      <= rd_req & oe;
      in_clk_q   <= in_clk;
      clk_byte_q <= rd_byte;
      if (tick_fast && !osc_stop) tog <= ~tog;
    end
  end

  assign rdata_drv = drv_q;
  assign rdata     = drv_q ? (in_clk_q ? clk_byte_q : ram_q) : 8'h00;

  // R10: no drive follows a cycle without power-good
  a_r10_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !rdata_drv);

  // R2: drive only follows an enabled read request
  a_r2_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drv |-> $past(ce && !we && oe && pwr_ok));
endmodule

// File: tb/rtc_nvram_core_test.sv
`timescale 1ns/1ps
module rtc_nvram_core_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, pwr_ok = 1'b1, ce = 1'b0, we = 1'b0, oe = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        tick_1hz = 1'b0, tick_fast = 1'b0;
  logic [7:0]  rdata;
  logic        rdata_drv, pfail_n;

  rtc_nvram_core uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce(ce), .we(we), .oe(oe),
    .addr(addr), .wdata(wdata), .tick_1hz(tick_1hz), .tick_fast(tick_fast),
    .rdata(rdata), .rdata_drv(rdata_drv), .pfail_n(pfail_n)
  );

  localparam logic [14:0] A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                          A_HR = 15'h7FFB, A_DAY = 15'h7FFC, A_DATE = 15'h7FFD,
                          A_MON = 15'h7FFE, A_YR = 15'h7FFF;

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       tog_m = 1'b0;

  // monitor: pops expected read data when the design drives
  always @(negedge clk) begin
    if (rst_n && rdata_drv) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected drive: actual %h expected no drive", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] ex);
    n_vec++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, ex);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); ce = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); ce = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string t);
    @(negedge clk); ce = 1'b1; we = 1'b0; oe = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); ce = 1'b0; oe = 1'b0;
  endtask

  task automatic rd_nodrive(input logic [14:0] a, input logic use_oe, input string t);
    @(negedge clk); ce = 1'b1; we = 1'b0; oe = use_oe; addr = a;
    @(negedge clk); ce = 1'b0; oe = 1'b0;
    chk({t, " drive"}, {7'd0, rdata_drv}, 8'h00);
    chk({t, " data"}, rdata, 8'h00);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic fast();
    @(negedge clk); tick_fast = 1'b1;
    @(negedge clk); tick_fast = 1'b0;
    tog_m = ~tog_m;
  endtask

  task automatic set_time(input logic [7:0] y, mo, dt, dw, h, mi, s);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_DAY, dw);
    wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, y);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pfail_n", {7'd0, pfail_n}, 8'h01);
    chk("R11 no drive", {7'd0, rdata_drv}, 8'h00);
    rd(A_CTRL, 8'h00, "R11 control");
    rd(A_SEC,  8'h80, "R11 seconds");
    rd(A_DAY,  8'h01, "R11 day");
    rd(A_DATE, 8'h01, "R11 date");
    rd(A_MON,  8'h01, "R11 month");
    rd(A_YR,   8'h00, "R11 year");

    // R1 byte store and aliasing, R2 no drive without oe
    wr(15'h0123, 8'hA5);
    wr(15'h7FF7, 8'h3C);
    rd(15'h0123, 8'hA5, "R1 ram");
    rd(15'h0523, 8'hA5, "R1 alias");
    rd(15'h7FF7, 8'h3C, "R1 below clock window");
    rd_nodrive(15'h0123, 1'b0, "R2 oe low");

    // R6 load under write hold, R3/R4 year rollover
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h58); wr(A_MIN, 8'h59); wr(A_HR, 8'h23); wr(A_DAY, 8'h07);
    wr(A_DATE, 8'h31); wr(A_MON, 8'h12); wr(A_YR, 8'h99);
    tick();
    rd(A_SEC, 8'h58, "R6 frozen under write hold");
    wr(A_CTRL, 8'h00);
    tick();
    rd(A_SEC, 8'h59, "R3 tick after transfer");
    tick();
    rd(A_SEC,  8'h00, "R3 sec wrap");
    rd(A_MIN,  8'h00, "R3 min wrap");
    rd(A_HR,   8'h00, "R3 hour wrap");
    rd(A_DAY,  8'h01, "R4 day wrap");
    rd(A_DATE, 8'h01, "R4 date wrap");
    rd(A_MON,  8'h01, "R4 month wrap");
    rd(A_YR,   8'h00, "R4 year wrap");

    // R4 month lengths
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h29, "R4 leap feb");
    rd(A_MON,  8'h02, "R4 leap feb month");
    rd(A_DAY,  8'h04, "R4 day advance");
    set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h01, "R4 plain feb");
    rd(A_MON,  8'h03, "R4 plain feb month");
    set_time(8'h23, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h01, "R4 30-day month");
    rd(A_MON,  8'h05, "R4 30-day month next");
    set_time(8'h23, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h01, "R4 31-day month");
    rd(A_MON,  8'h02, "R4 31-day month next");

    // R8 frequency test
    set_time(8'h24, 8'h06, 8'h15, 8'h42, 8'h12, 8'h30, 8'h05);
    rd(A_DAY, 8'h42, "R8 test bit kept");
    rd(A_SEC, {7'h02, tog_m}, "R8 toggle initial");
    fast();
    rd(A_SEC, {7'h02, tog_m}, "R8 toggle flipped");
    fast();
    rd(A_SEC, {7'h02, tog_m}, "R8 toggle back");
    wr(A_DAY, 8'h02);
    rd(A_SEC, 8'h05, "R8 test off");

    // R9 spare bits
    wr(A_MIN, 8'hB0);
    rd(A_MIN, 8'hB0, "R9 min spare write");
    tick();
    rd(A_MIN, 8'hB0, "R9 min spare after tick");
    rd(A_SEC, 8'h06, "R3 tick tracks");
    wr(A_MIN, 8'h30);
    wr(A_HR, 8'hD2);
    rd(A_HR, 8'hD2, "R9 hour spare");
    wr(A_HR, 8'h12);
    wr(A_CTRL, 8'h2A);
    rd(A_CTRL, 8'h2A, "R9 control spare");
    wr(A_CTRL, 8'h00);

    // R5 read hold
    wr(A_CTRL, 8'h40);
    tick(); tick(); tick();
    rd(A_SEC, 8'h06, "R5 frozen");
    rd(A_CTRL, 8'h40, "R5 control");
    wr(A_CTRL, 8'h00);
    rd(A_SEC, 8'h09, "R5 refresh after release");
    rd(A_MIN, 8'h30, "R5 minutes after release");

    // R6 transfer priority with read hold set in the same write
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h20);
    wr(A_CTRL, 8'h40);
    tick();
    rd(A_SEC, 8'h20, "R6 frozen after transfer");
    wr(A_CTRL, 8'h00);
    rd(A_SEC, 8'h21, "R6 transfer taken");

    // R7 oscillator stop
    wr(A_SEC, 8'hA1);
    tick(); tick();
    rd(A_SEC, 8'hA1, "R7 stopped");
    wr(A_SEC, 8'h21);
    tick();
    rd(A_SEC, 8'h22, "R7 counters held");

    // R10 power fail
    @(negedge clk); pwr_ok = 1'b0;
    @(negedge clk);
    chk("R10 pfail_n", {7'd0, pfail_n}, 8'h00);
    wr(15'h0123, 8'h00);
    wr(A_CTRL, 8'h80);
    rd_nodrive(15'h0123, 1'b1, "R10 read blocked");
    @(negedge clk); pwr_ok = 1'b1;
    rd(15'h0123, 8'hA5, "R10 write blocked");
    rd(A_CTRL, 8'h00, "R10 control write blocked");

    repeat (3) @(negedge clk);
    chk("R2 all reads answered", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule